// File: doc/BRIEF.md
# Packet buffer MMU controller

This block keeps track of a small pool of fixed-size packet pages inside a network controller. It owns the page-occupancy bitmap and three short queues of page numbers. The receive queue holds pages that carry received frames. The transmit queue holds pages waiting to go out. The completion queue holds pages whose transmission has finished and which software has not yet reclaimed. The packet memory, the MAC and the bus decoder sit outside. The block sees only page numbers, command strobes and handshakes.

Software drives the block through a 3-bit command code, a selected page number, an acknowledge write and a mask write. The receive path asks for a page with `rx_req` and is granted one in the same cycle. The transmit path sees the head of the transmit queue and retires it with `tx_done`. An 8-bit interrupt status register is combined with an 8-bit mask to drive one interrupt line.

A transmit allocation that finds no free page stays pending. It completes on its own in the first cycle in which a page is free.

Top module: `pktpage_mmu`

## Requirements
- R1: After reset: no page is in use, the allocation result is 0, the interrupt status is 0x04, the mask is 0 and `irq` is low.
- R2: Allocation always takes the lowest-numbered free page. When a receive request and a transmit allocation are served in the same cycle, the receive side gets the lowest free page and the transmit side gets the next one.
- R3: Command 1 (allocate for transmit) sets the result to 0x80 and clears status bit 3. If a page is granted, the result holds that page number and bit 3 is set, both visible after the command's clock edge. With no free page, the result stays 0x80 and the request stays pending.
- R4: A pending transmit allocation is granted in the first cycle that starts with a free page. After a release command, the granted page appears in the result two edges after the command.
- R5: Command 5 frees the page given on `pkt_sel`. Command 2 empties the bitmap and all three queues, drops any pending allocation and sets the result to 0.
- R6: A receive is granted when the receiver is enabled, not held, a page is free and the receive queue is not full. The page is pushed on the receive queue and status bit 0 is set. `rx_gate` is high when the receiver is disabled or held, or when a page is free and the receive queue has room.
- R7: Command 3 removes the head of the receive queue and command 4 also frees that head page; the remaining entries move forward. Bit 0 stays set if entries remain and is cleared if the queue empties. Either command on an empty queue leaves the queue and the bitmap unchanged.
- R8: Command 6 appends `pkt_sel` to the transmit queue and is dropped when the queue is full. `tx_req` and `tx_page` show the queue head. Command 7 empties the transmit and completion queues.
- R9: `tx_done` removes the transmit head. If `auto_release` is set, the page is freed. Otherwise it is appended to the completion queue, and dropped if that queue is full and not being popped. `tx_done` is ignored in a cycle with command 2 or 7.
- R10: Status bit 2 is set whenever the transmit queue is empty, and an acknowledge clears it only while the queue holds entries. Status bit 1 is set whenever the completion queue is not empty.
- R11: An acknowledge write clears the status bits selected by (value AND 0xD6). If value bit 1 is set, the head of the completion queue is also removed.
- R12: A mask write loads the mask; `irq` is high exactly when (status AND mask) is nonzero.
- R13: `rx_head` and `done_head` read 0x80 when their queue is empty. `pages_used` equals the number of set bits in the occupancy bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (bits 7:5 of the written byte) |
| pkt_sel | input | PW (2) | Page number for release and enqueue |
| auto_release | input | 1 | Free pages on transmit completion |
| rx_enable | input | 1 | Receiver enabled |
| rx_hold | input | 1 | Receiver held in soft reset |
| rx_req | input | 1 | Receive path requests a page |
| rx_grant | output | 1 | Page granted to receive path this cycle |
| rx_page | output | PW (2) | Granted receive page |
| rx_gate | output | 1 | Receive path may offer a frame |
| tx_req | output | 1 | Transmit queue not empty |
| tx_page | output | PW (2) | Head of transmit queue |
| tx_done | input | 1 | Transmission of head page finished |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_val | input | 8 | Acknowledge bit pattern |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_val | input | 8 | New mask value |
| alloc_result | output | 8 | Transmit allocation result, 0x80 when none |
| done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| pages_used | output | CW (3) | Count of allocated pages |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
The receive grant and a transmit allocation command can both be served in one cycle. They compete for the same free pages. The bench provokes this for every one of the 16 occupancy patterns of a 4-page pool. It fills the pool with allocations, releases the pages that the pattern marks free, then raises `rx_req` in the same cycle as command 1. The expected pages are the lowest and second-lowest clear bits of the pattern, or no grant and 0x80 when too few are free. The grant is sampled before the edge, and the result, bit 3 and the page count after it.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
   typedef enum logic [2:0] {
      MC_NOP         = 3'd0,
      MC_TX_ALLOC    = 3'd1,
      MC_RESET       = 3'd2,
      MC_RX_POP      = 3'd3,
      MC_RX_POP_FREE = 3'd4,
      MC_RELEASE     = 3'd5,
      MC_TX_ENQ      = 3'd6,
      MC_TX_CLR      = 3'd7
   } mmu_cmd_e;

   localparam int IB_RCV   = 0;
   localparam int IB_TX    = 1;
   localparam int IB_TXE   = 2;
   localparam int IB_ALLOC = 3;

   localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
   localparam logic [7:0] NO_PAGE       = 8'h80;
   localparam logic [7:0] STATUS_RST    = 8'h04;
endpackage

// File: rtl/pm_queue.sv
`timescale 1ns/1ps
module pm_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int QCW  = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           push,
   input  logic [W-1:0]   din,
   input  logic           pop,
   output logic [W-1:0]   head,
   output logic [QCW-1:0] count,
   output logic [QCW-1:0] count_nxt,
   output logic           empty,
   output logic           full
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pm_queue: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("pm_queue: W must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] ent;
   logic                    pop_ok, push_ok;
   logic [QCW-1:0]          wp;

   assign empty = (count == '0);
   assign full  = (count == QCW'(DEPTH));
   assign head  = ent[0];

   always_comb begin
      pop_ok    = pop && !empty && !clr;
      push_ok   = push && !clr && (!full || pop_ok);
      wp        = count - QCW'(pop_ok);
      count_nxt = clr ? '0 : (count - QCW'(pop_ok) + QCW'(push_ok));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ent   <= '0;
      end else begin
         count <= count_nxt;
         for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && wp == QCW'(i))
               ent[i] <= din;
            else if (pop_ok && i < DEPTH - 1)
               ent[i] <= ent[(i < DEPTH - 1) ? i + 1 : i];
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= QCW'(DEPTH)); // R8
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (full && $stable(head))); // R9
endmodule

// File: rtl/pm_alloc.sv
`timescale 1ns/1ps
module pm_alloc #(
   parameter int NPAGES = 4,
   localparam int PW    = (NPAGES > 1) ? $clog2(NPAGES) : 1,
   localparam int CW    = $clog2(NPAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rx_try,
   input  logic              tx_try,
   input  logic [NPAGES-1:0] rel_mask,
   output logic              rx_ok,
   output logic [PW-1:0]     rx_page,
   output logic              tx_ok,
   output logic [PW-1:0]     tx_page,
   output logic              all_used,
   output logic [CW-1:0]     used_cnt
);
   generate
      if (NPAGES < 1 || NPAGES > 127) begin : g_bad_pages
         $error("pm_alloc: NPAGES must lie in 1..127");
      end
   endgenerate

   localparam logic [NPAGES-1:0] ONE = NPAGES'(1);

   logic [NPAGES-1:0] used_map, free1, free2, take;
   logic [PW:0]       pick1, pick2;

   function automatic logic [PW:0] lowest(input logic [NPAGES-1:0] v);
      logic [PW:0] r;
      r = '0;
      for (int i = NPAGES - 1; i >= 0; i--)
         if (v[i]) r = {1'b1, PW'(i)};
      return r;
   endfunction

   always_comb begin
      free1   = ~used_map;
      pick1   = lowest(free1);
      rx_ok   = rx_try && pick1[PW] && !clr;
      rx_page = pick1[PW-1:0];
      free2   = free1 & ~(rx_ok ? (ONE << rx_page) : '0);
      pick2   = lowest(free2);
      tx_ok   = tx_try && pick2[PW] && !clr;
      tx_page = pick2[PW-1:0];
      take    = (rx_ok ? (ONE << rx_page) : '0) | (tx_ok ? (ONE << tx_page) : '0);
      all_used = &used_map;
      used_cnt = '0;
      for (int i = 0; i < NPAGES; i++)
         used_cnt = used_cnt + CW'(used_map[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         used_map <= '0;
      else if (clr)
         used_map <= '0;
      else
         used_map <= (used_map & ~rel_mask) | take;
   end

   AST_DISTINCT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok && tx_ok) |-> (rx_page != tx_page)); // R2
   AST_RX_TAKES_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ok |=> used_map[$past(rx_page)]); // R6
endmodule

// File: rtl/pm_irq.sv
`timescale 1ns/1ps
module pm_irq
   import pm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] set_bits,
   input  logic [7:0] clr_bits,
   input  logic       mask_we,
   input  logic [7:0] mask_val,
   output logic [7:0] status,
   output logic [7:0] mask,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= STATUS_RST;
         mask   <= '0;
      end else begin
         status <= (status & ~clr_bits) | set_bits;
         if (mask_we) mask <= mask_val;
      end
   end

   assign irq = |(status & mask);

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask == $past(mask_val))); // R12
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((status & $past(set_bits)) == $past(set_bits))); // R3
endmodule

// File: rtl/pktpage_mmu.sv
`timescale 1ns/1ps
module pktpage_mmu
   import pm_pkg::*;
#(
   parameter int NPAGES = 4,
   parameter int QDEPTH = NPAGES,
   localparam int PW    = (NPAGES > 1) ? $clog2(NPAGES) : 1,
   localparam int CW    = $clog2(NPAGES + 1),
   localparam int QCW   = $clog2(QDEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic [2:0]    cmd_op,
   input  logic [PW-1:0] pkt_sel,
   input  logic          auto_release,
   input  logic          rx_enable,
   input  logic          rx_hold,
   input  logic          rx_req,
   output logic          rx_grant,
   output logic [PW-1:0] rx_page,
   output logic          rx_gate,
   output logic          tx_req,
   output logic [PW-1:0] tx_page,
   input  logic          tx_done,
   input  logic          ack_we,
   input  logic [7:0]    ack_val,
   input  logic          mask_we,
   input  logic [7:0]    mask_val,
   output logic [7:0]    alloc_result,
   output logic [7:0]    done_head,
   output logic [7:0]    rx_head,
   output logic [CW-1:0] pages_used,
   output logic [7:0]    int_status,
   output logic [7:0]    int_mask,
   output logic          irq
);
   generate
      if (QDEPTH < 1) begin : g_bad_qdepth
         $error("pktpage_mmu: QDEPTH must be at least 1");
      end
   endgenerate

   localparam logic [NPAGES-1:0] ONE = NPAGES'(1);

   mmu_cmd_e          cmd;
   logic              do_reset, q_clr, rx_pop, rx_free, alloc_cmd;
   logic              rx_try, tx_try, tx_ok, all_used, tx_fire, alloc_pend;
   logic [PW-1:0]     tx_alloc_page;
   logic [NPAGES-1:0] rel_mask;
   logic [7:0]        set_bits, clr_bits;

   logic [PW-1:0]  rxq_head, txq_head, dq_head;
   logic [QCW-1:0] rxq_cnt, rxq_nxt, txq_cnt, txq_nxt, dq_cnt, dq_nxt;
   logic           rxq_empty, rxq_full, txq_empty, txq_full, dq_empty, dq_full;

   always_comb begin
      cmd       = cmd_we ? mmu_cmd_e'(cmd_op) : MC_NOP;
      do_reset  = (cmd == MC_RESET);
      q_clr     = do_reset || (cmd == MC_TX_CLR);
      alloc_cmd = (cmd == MC_TX_ALLOC);
      rx_pop    = (cmd == MC_RX_POP) || (cmd == MC_RX_POP_FREE);
      rx_free   = (cmd == MC_RX_POP_FREE) && !rxq_empty;
      rx_try    = rx_req && rx_enable && !rx_hold && !rxq_full && !do_reset;
      tx_try    = alloc_cmd || alloc_pend;
      tx_fire   = tx_done && !txq_empty && !q_clr;
      rel_mask  = (rx_free ? (ONE << rxq_head) : '0)
                | ((cmd == MC_RELEASE) ? (ONE << pkt_sel) : '0)
                | ((tx_fire && auto_release) ? (ONE << txq_head) : '0);
      rx_gate   = !rx_enable || rx_hold || (!all_used && !rxq_full);
   end

   pm_alloc #(.NPAGES(NPAGES)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (do_reset),
      .rx_try   (rx_try),
      .tx_try   (tx_try),
      .rel_mask (rel_mask),
      .rx_ok    (rx_grant),
      .rx_page  (rx_page),
      .tx_ok    (tx_ok),
      .tx_page  (tx_alloc_page),
      .all_used (all_used),
      .used_cnt (pages_used)
   );

   pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(do_reset),
      .push(rx_grant), .din(rx_page), .pop(rx_pop),
      .head(rxq_head), .count(rxq_cnt), .count_nxt(rxq_nxt),
      .empty(rxq_empty), .full(rxq_full)
   );

   pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(q_clr),
      .push(cmd == MC_TX_ENQ), .din(pkt_sel), .pop(tx_fire),
      .head(txq_head), .count(txq_cnt), .count_nxt(txq_nxt),
      .empty(txq_empty), .full(txq_full)
   );

   pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_doneq (
      .clk(clk), .rst_n(rst_n), .clr(q_clr),
      .push(tx_fire && !auto_release), .din(txq_head),
      .pop(ack_we && ack_val[IB_TX]),
      .head(dq_head), .count(dq_cnt), .count_nxt(dq_nxt),
      .empty(dq_empty), .full(dq_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_pend   <= 1'b0;
         alloc_result <= '0;
      end else if (do_reset) begin
         alloc_pend   <= 1'b0;
         alloc_result <= '0;
      end else if (tx_ok) begin
         alloc_pend   <= 1'b0;
         alloc_result <= 8'(tx_alloc_page);
      end else if (alloc_cmd) begin
         alloc_pend   <= 1'b1;
         alloc_result <= NO_PAGE;
      end
   end

   always_comb begin
      set_bits           = '0;
      set_bits[IB_RCV]   = rx_grant || (rx_pop && rxq_nxt != '0);
      set_bits[IB_TX]    = (dq_nxt != '0);
      set_bits[IB_TXE]   = (txq_nxt == '0);
      set_bits[IB_ALLOC] = tx_ok;
      clr_bits           = ack_we ? (ack_val & ACK_CLEARABLE) : '0;
      clr_bits[IB_RCV]   = rx_pop && rxq_nxt == '0;
      clr_bits[IB_ALLOC] = alloc_cmd;
   end

   pm_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_bits),
      .clr_bits (clr_bits),
      .mask_we  (mask_we),
      .mask_val (mask_val),
      .status   (int_status),
      .mask     (int_mask),
      .irq      (irq)
   );

   assign tx_req    = !txq_empty;
   assign tx_page   = txq_head;
   assign rx_head   = rxq_empty ? NO_PAGE : 8'(rxq_head);
   assign done_head = dq_empty ? NO_PAGE : 8'(dq_head);

   AST_TXE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      txq_empty |-> int_status[IB_TXE]); // R10
   AST_TX_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_empty |-> int_status[IB_TX]); // R10
   AST_PEND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_pend |-> (alloc_result == NO_PAGE)); // R3
   AST_RX_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (all_used || rxq_full) |-> !rx_grant); // R6
   AST_RCV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_grant && rxq_cnt == QCW'(1)) |=> !int_status[IB_RCV]); // R7
endmodule

// File: tb/sim_pktpage_mmu.sv
`timescale 1ns/1ps
module sim_pktpage_mmu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_we = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [1:0] pkt_sel = '0;
   logic       auto_release = 1'b0;
   logic       rx_enable = 1'b0;
   logic       rx_hold = 1'b0;
   logic       rx_req = 1'b0;
   logic       rx_grant;
   logic [1:0] rx_page;
   logic       rx_gate;
   logic       tx_req;
   logic [1:0] tx_page;
   logic       tx_done = 1'b0;
   logic       ack_we = 1'b0;
   logic [7:0] ack_val = '0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_val = '0;
   logic [7:0] alloc_result, done_head, rx_head, int_status, int_mask;
   logic [2:0] pages_used;
   logic       irq;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pktpage_mmu #(.NPAGES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op),
      .pkt_sel(pkt_sel), .auto_release(auto_release),
      .rx_enable(rx_enable), .rx_hold(rx_hold), .rx_req(rx_req),
      .rx_grant(rx_grant), .rx_page(rx_page), .rx_gate(rx_gate),
      .tx_req(tx_req), .tx_page(tx_page), .tx_done(tx_done),
      .ack_we(ack_we), .ack_val(ack_val), .mask_we(mask_we),
      .mask_val(mask_val), .alloc_result(alloc_result),
      .done_head(done_head), .rx_head(rx_head), .pages_used(pages_used),
      .int_status(int_status), .int_mask(int_mask), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic cmd(input logic [2:0] c, input logic [1:0] p);
      cmd_we = 1'b1; cmd_op = c; pkt_sel = p;
      tick;
      cmd_we = 1'b0;
   endtask

   task automatic ack(input logic [7:0] v);
      ack_we = 1'b1; ack_val = v;
      tick;
      ack_we = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] v);
      mask_we = 1'b1; mask_val = v;
      tick;
      mask_we = 1'b0;
   endtask

   task automatic txd;
      tx_done = 1'b1;
      tick;
      tx_done = 1'b0;
   endtask

   initial begin
      #500000;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      tick; tick;
      rst_n = 1'b1;
      tick;
      // R1 / R13 reset state
      chk("R1 used", pages_used, 0);
      chk("R1 result", alloc_result, 0);
      chk("R1 status", int_status, 8'h04);
      chk("R1 mask", int_mask, 0);
      chk("R1 irq", irq, 0);
      chk("R13 rx_head empty", rx_head, 8'h80);
      chk("R13 done_head empty", done_head, 8'h80);
      chk("R8 tx_req idle", tx_req, 0);
      chk("R6 gate when disabled", rx_gate, 1);

      rx_enable = 1'b1;
      // R2 sweep: every occupancy pattern, rx and tx allocation in one cycle
      for (int s = 0; s < 16; s++) begin
         int f1, f2, pc;
         cmd(3'd2, 2'd0);
         for (int k = 0; k < 4; k++) cmd(3'd1, 2'd0);
         for (int k = 0; k < 4; k++) if (!s[k]) cmd(3'd5, 2'(k));
         pc = 0; f1 = -1; f2 = -1;
         for (int k = 0; k < 4; k++) begin
            if (s[k]) pc++;
            else if (f1 < 0) f1 = k;
            else if (f2 < 0) f2 = k;
         end
         chk("R13 popcount", pages_used, pc);
         rx_req = 1'b1; cmd_we = 1'b1; cmd_op = 3'd1;
         #1;
         chk("R2 rx grant", rx_grant, (f1 >= 0) ? 1 : 0);
         if (f1 >= 0) chk("R2 rx lowest page", rx_page, f1);
         tick;
         rx_req = 1'b0; cmd_we = 1'b0;
         chk("R2 tx second page", alloc_result, (f2 >= 0) ? f2 : 8'h80);
         chk("R3 alloc bit", int_status[3], (f2 >= 0) ? 1 : 0);
         chk("R2 used after", pages_used, pc + (f1 >= 0 ? 1 : 0) + (f2 >= 0 ? 1 : 0));
      end

      // R3 / R4 pending allocation retried after release
      cmd(3'd2, 2'd0);
      chk("R5 reset result", alloc_result, 0);
      chk("R5 reset used", pages_used, 0);
      for (int k = 0; k < 4; k++) begin
         cmd(3'd1, 2'd0);
         chk("R3 grant order", alloc_result, k);
      end
      cmd(3'd1, 2'd0);
      chk("R3 full result", alloc_result, 8'h80);
      chk("R3 alloc bit cleared", int_status[3], 0);
      cmd(3'd5, 2'd2);
      chk("R4 not yet", alloc_result, 8'h80);
      tick;
      chk("R4 retry page", alloc_result, 2);
      chk("R4 alloc bit", int_status[3], 1);
      chk("R4 used", pages_used, 4);

      // R6 / R7 receive queue
      cmd(3'd2, 2'd0);
      rx_req = 1'b1;
      tick; tick; tick;
      rx_req = 1'b0;
      chk("R6 used", pages_used, 3);
      chk("R6 head", rx_head, 0);
      chk("R6 rcv", int_status[0], 1);
      cmd(3'd3, 2'd0);
      chk("R7 pop head", rx_head, 1);
      chk("R7 rcv kept", int_status[0], 1);
      chk("R7 pop no release", pages_used, 3);
      cmd(3'd4, 2'd0);
      chk("R7 pop-free head", rx_head, 2);
      chk("R7 pop-free used", pages_used, 2);
      cmd(3'd4, 2'd0);
      chk("R7 emptied head", rx_head, 8'h80);
      chk("R7 rcv cleared", int_status[0], 0);
      chk("R7 used", pages_used, 1);
      cmd(3'd4, 2'd0);
      chk("R7 empty pop head", rx_head, 8'h80);
      chk("R7 empty pop used", pages_used, 1);
      rx_enable = 1'b0; rx_req = 1'b1;
      #1;
      chk("R6 disabled gate", rx_gate, 1);
      chk("R6 disabled no grant", rx_grant, 0);
      tick;
      chk("R6 disabled used", pages_used, 1);
      rx_enable = 1'b1;
      tick; tick; tick;
      #1;
      chk("R6 full gate", rx_gate, 0);
      chk("R6 full no grant", rx_grant, 0);
      rx_req = 1'b0;
      chk("R6 full head", rx_head, 1);

      // R11 / R12 acknowledge mask and interrupt line
      ack(8'hFF);
      chk("R11 rcv survives", int_status[0], 1);
      chk("R11 txe survives", int_status[2], 1);
      set_mask(8'h01);
      chk("R12 irq on", irq, 1);
      set_mask(8'h00);
      chk("R12 irq off", irq, 0);

      // R8 / R9 / R10 / R11 transmit path
      cmd(3'd2, 2'd0);
      cmd(3'd1, 2'd0);
      cmd(3'd6, 2'd0);
      chk("R8 tx_req", tx_req, 1);
      chk("R8 tx_page", tx_page, 0);
      ack(8'h04);
      chk("R10 txe acked", int_status[2], 0);
      txd;
      chk("R9 tx drained", tx_req, 0);
      chk("R9 done head", done_head, 0);
      chk("R10 tx bit", int_status[1], 1);
      chk("R10 txe reset", int_status[2], 1);
      set_mask(8'h02);
      chk("R12 irq tx", irq, 1);
      ack(8'h02);
      chk("R11 done popped", done_head, 8'h80);
      chk("R11 tx cleared", int_status[1], 0);
      chk("R12 irq drop", irq, 0);
      chk("R9 page kept", pages_used, 1);
      cmd(3'd6, 2'd0);
      auto_release = 1'b1;
      txd;
      auto_release = 1'b0;
      chk("R9 auto release", pages_used, 0);
      chk("R9 auto no done", done_head, 8'h80);

      for (int k = 0; k < 5; k++) cmd(3'd6, 2'(k));
      for (int k = 0; k < 4; k++) begin
         chk("R8 tx order", tx_page, k);
         txd;
      end
      chk("R8 fifth dropped", tx_req, 0);
      chk("R9 done order", done_head, 0);
      cmd(3'd7, 2'd0);
      chk("R8 clear done", done_head, 8'h80);

      for (int k = 0; k < 4; k++) cmd(3'd6, 2'(k));
      for (int k = 0; k < 4; k++) txd;
      cmd(3'd6, 2'd3);
      txd;
      for (int k = 0; k < 4; k++) begin
         chk("R9 done fifo", done_head, k);
         ack(8'h02);
      end
      chk("R9 overflow dropped", done_head, 8'h80);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule